// File: doc/BRIEF.md
# Interrupt Controller Register Port

This block is the byte-wide programming front end of an eight-line interrupt controller. Software reaches it through three byte ports: command, data and trigger mode. Each port has its own write strobe and read strobe, and all three share one write-data bus and one read-data bus. The block turns what software writes into four things:
- the mask register;
- the vector base;
- the mode flags;
- single-cycle control pulses for the priority resolver that sits beside it.

The block does not resolve priority itself. The resolver supplies the request register, the in-service register and its current highest-priority pending line. The block hands back clear masks for those registers.

A command write is classified by its bits, not by its address:
- Bit 4 set starts initialization.
- Otherwise, bit 3 set selects the read/poll/special-mask command.
- Any other value is an end-of-interrupt or priority command.

After initialization starts, a small sequencer takes the following data writes as the vector base, an ignored cascade word and, if one was requested, a mode word. Later data writes load the mask.

Reads are combinational from current state. A poll read returns the highest-priority pending line and clears it in the resolver on the next cycle.

Top module: `pic_port_ctl`

## Requirements
- R1: After reset the mask, trigger-mode register, vector base, auto-EOI, special-nesting, rotate-on-auto-EOI and special-mask flags are all zero. The sequencer is idle, poll is disarmed, and a command-port read returns the request register.
- R2: A command write with bit 4 set is an init command (init_p pulses). Else, with bit 3 set, it is a read/poll command and produces no EOI or priority pulse. Else it is an EOI/priority command.
- R3: An init command clears the mask, vector base, special-mask flag and read-select, and it pulses init_p. In the next cycle req_clr equals the inverse of the trigger-mode register, which clears edge-mode requests and keeps level-mode requests.
- R4: An init command with bit 0 clear also clears auto-EOI and special-nesting. With bit 0 set, both flags are kept.
- R5: After an init command, the first data write stores its bits 7:3 as the vector base, and the second data write changes nothing, including the mask. If bit 0 of the init command was set, a third data write is the mode word. Any later data write loads the mask.
- R6: The mode word sets special-nesting from bit 4 and auto-EOI from bit 1.
- R7: In an EOI/priority command, bits 7:5 give the code. Codes 001, 011, 101 and 111 give a one-cycle eoi_p. eoi_specific is high for 011 and 111, eoi_rotate is high for 101 and 111, and cmd_line carries bits 2:0.
- R8: Code 100 sets rotate-on-auto-EOI and code 000 clears it. Code 010 changes nothing and pulses nothing. Code 110 pulses prio_set_p, with bits 2:0 on cmd_line.
- R9: In a read/poll command, bit 1 enables an update of read-select to bit 0 (1 = in-service, 0 = request). Bit 6 enables an update of special-mask to bit 5. Without its enable bit, a field is left as it was. Bit 2 arms poll.
- R10: While poll is armed, a read of the command or data port returns the resolver's line, or 7 when nothing is pending. If a line was returned, req_clr and isr_clr carry that line's bit in the next cycle. The read disarms poll.
- R11: When poll is not armed, a command-port read returns the in-service or request register as read-select chooses, and a data-port read returns the mask. The trigger-mode port is written and read back directly.
- R12: If a poll read and a command write that re-arms poll fall in the same cycle, the read still returns the poll result and its clears are still issued. Poll stays armed for the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command port write strobe |
| cmd_rd | input | 1 | Command port read strobe |
| data_wr | input | 1 | Data port write strobe |
| data_rd | input | 1 | Data port read strobe |
| trig_wr | input | 1 | Trigger-mode port write strobe |
| trig_rd | input | 1 | Trigger-mode port read strobe |
| wdata | input | 8 | Write data shared by all ports |
| rdata | output | 8 | Read data of the strobed port (zero when none is strobed) |
| req_vec | input | 8 | Resolver request register |
| isr_vec | input | 8 | Resolver in-service register |
| poll_hit | input | 1 | Resolver has a deliverable line |
| poll_line | input | 3 | Resolver's highest-priority deliverable line |
| mask | output | 8 | Line mask register |
| trig_mode | output | 8 | Per-line trigger mode, 1 = level |
| vec_base | output | 5 | Vector base (upper bits of the vector) |
| auto_eoi | output | 1 | Automatic EOI mode |
| spec_nest | output | 1 | Special fully nested mode |
| rot_on_aeoi | output | 1 | Rotate priority on automatic EOI |
| spec_mask | output | 1 | Special mask mode |
| init_busy | output | 1 | Initialization sequence in progress |
| init_p | output | 1 | Pulse: initialization command accepted |
| eoi_p | output | 1 | Pulse: EOI command |
| eoi_specific | output | 1 | EOI targets cmd_line |
| eoi_rotate | output | 1 | EOI also rotates priority |
| prio_set_p | output | 1 | Pulse: set lowest priority to cmd_line |
| cmd_line | output | 3 | Line field of the last EOI/priority command |
| req_clr | output | 8 | Request bits to clear (poll or init) |
| isr_clr | output | 8 | In-service bits to clear (poll) |

## Verification
A poll read and a command write that arms poll again can occur in the same cycle. The bench provokes this by strobing cmd_rd and cmd_wr together with a poll-arming command value while poll is already armed. It judges three things: the read data must be the resolver's line, the clear masks must follow one cycle later, and a second data-port read must return the poll result again because poll stayed armed. A second overlap occurs when an init command and a poll read coincide. In that case the clear mask is the OR of the edge-mode clear and the polled line.

// File: rtl/pic_port_pkg.sv
package pic_port_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BASE = 2'd1,
    ST_CASC = 2'd2,
    ST_MODE = 2'd3
  } init_st_t;

  typedef enum logic [2:0] {
    OP_ROT_CLR = 3'd0,
    OP_EOI     = 3'd1,
    OP_NOP     = 3'd2,
    OP_SEOI    = 3'd3,
    OP_ROT_SET = 3'd4,
    OP_REOI    = 3'd5,
    OP_PRIO    = 3'd6,
    OP_RSEOI   = 3'd7
  } op2_t;

endpackage

// File: rtl/pic_cmd_decode.sv
module pic_cmd_decode
  import pic_port_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          cmd_wr,
  input  logic [DW-1:0] wdata,
  output logic          is_init,
  output logic          is_rdcmd,
  output logic          is_opcmd,
  output op2_t          op
);
  localparam int OPW = 3;

  always_comb begin
    is_init  = cmd_wr & wdata[4];
    is_rdcmd = cmd_wr & ~wdata[4] & wdata[3];
    is_opcmd = cmd_wr & ~wdata[4] & ~wdata[3];
    op       = op2_t'(wdata[DW-1 -: OPW]);
  end
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_port_pkg::*;
#(
  parameter int DW = 8,
  localparam int LW = $clog2(DW),
  localparam int BW = DW - LW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          is_init,
  input  logic          data_wr,
  input  logic [DW-1:0] wdata,
  output init_st_t      st,
  output logic [DW-1:0] mask,
  output logic [BW-1:0] vec_base,
  output logic          auto_eoi,
  output logic          spec_nest,
  output logic          init_p
);
  logic need_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      mask      <= '0;
      vec_base  <= '0;
      auto_eoi  <= 1'b0;
      spec_nest <= 1'b0;
      need_mode <= 1'b0;
      init_p    <= 1'b0;
    end else begin
      init_p <= is_init;
      if (is_init) begin
        need_mode <= wdata[0];
        mask      <= '0;
        vec_base  <= '0;
        st        <= ST_BASE;
        if (!wdata[0]) begin
          auto_eoi  <= 1'b0;
          spec_nest <= 1'b0;
        end
      end else if (data_wr) begin
        unique case (st)
          ST_IDLE: mask <= wdata;
          ST_BASE: begin
            vec_base <= wdata[DW-1:LW];
            st       <= ST_CASC;
          end
          ST_CASC: st <= need_mode ? ST_MODE : ST_IDLE;
          ST_MODE: begin
            spec_nest <= wdata[4];
            auto_eoi  <= wdata[1];
            st        <= ST_IDLE;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/pic_op_ctl.sv
module pic_op_ctl
  import pic_port_pkg::*;
#(
  parameter int DW = 8,
  localparam int LW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          is_init,
  input  logic          is_rdcmd,
  input  logic          is_opcmd,
  input  op2_t          op,
  input  logic [DW-1:0] wdata,
  input  logic          poll_rd,
  input  logic          poll_hit,
  input  logic [LW-1:0] poll_line,
  input  logic [DW-1:0] trig_mode,
  output logic          poll_armed,
  output logic          read_isr,
  output logic          spec_mask,
  output logic          rot_on_aeoi,
  output logic          eoi_p,
  output logic          eoi_specific,
  output logic          eoi_rotate,
  output logic          prio_set_p,
  output logic [LW-1:0] cmd_line,
  output logic [DW-1:0] req_clr,
  output logic [DW-1:0] isr_clr
);
  logic [DW-1:0] poll_bit;
  logic          op_eoi;

  always_comb begin
    poll_bit = '0;
    if (poll_rd && poll_hit) poll_bit[poll_line] = 1'b1;
    op_eoi = is_opcmd & ((op == OP_EOI) | (op == OP_SEOI) |
                         (op == OP_REOI) | (op == OP_RSEOI));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      poll_armed   <= 1'b0;
      read_isr     <= 1'b0;
      spec_mask    <= 1'b0;
      rot_on_aeoi  <= 1'b0;
      eoi_p        <= 1'b0;
      eoi_specific <= 1'b0;
      eoi_rotate   <= 1'b0;
      prio_set_p   <= 1'b0;
      cmd_line     <= '0;
      req_clr      <= '0;
      isr_clr      <= '0;
    end else begin
      eoi_p      <= op_eoi;
      prio_set_p <= is_opcmd & (op == OP_PRIO);
      isr_clr    <= poll_bit;
      req_clr    <= poll_bit | (is_init ? ~trig_mode : '0);
      if (is_opcmd) begin
        cmd_line     <= wdata[LW-1:0];
        eoi_specific <= (op == OP_SEOI) | (op == OP_RSEOI);
        eoi_rotate   <= (op == OP_REOI) | (op == OP_RSEOI);
        if (op == OP_ROT_SET) rot_on_aeoi <= 1'b1;
        if (op == OP_ROT_CLR) rot_on_aeoi <= 1'b0;
      end
      if (is_rdcmd && wdata[2]) poll_armed <= 1'b1;
      else if (poll_rd)         poll_armed <= 1'b0;
      if (is_init) begin
        read_isr  <= 1'b0;
        spec_mask <= 1'b0;
      end else if (is_rdcmd) begin
        if (wdata[1]) read_isr  <= wdata[0];
        if (wdata[6]) spec_mask <= wdata[5];
      end
    end
  end
endmodule

// File: rtl/pic_readback.sv
module pic_readback #(
  parameter int DW = 8,
  localparam int LW = $clog2(DW)
) (
  input  logic          cmd_rd,
  input  logic          data_rd,
  input  logic          trig_rd,
  input  logic          poll_armed,
  input  logic          read_isr,
  input  logic          poll_hit,
  input  logic [LW-1:0] poll_line,
  input  logic [DW-1:0] req_vec,
  input  logic [DW-1:0] isr_vec,
  input  logic [DW-1:0] mask,
  input  logic [DW-1:0] trig_mode,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] poll_val;

  always_comb begin
    poll_val = {{(DW-LW){1'b0}}, (poll_hit ? poll_line : {LW{1'b1}})};
    if (cmd_rd)
      rdata = poll_armed ? poll_val : (read_isr ? isr_vec : req_vec);
    else if (data_rd)
      rdata = poll_armed ? poll_val : mask;
    else if (trig_rd)
      rdata = trig_mode;
    else
      rdata = '0;
  end
endmodule

// File: rtl/pic_port_ctl.sv
module pic_port_ctl
  import pic_port_pkg::*;
#(
  parameter int DW = 8,
  localparam int LW = $clog2(DW),
  localparam int BW = DW - LW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_wr,
  input  logic          cmd_rd,
  input  logic          data_wr,
  input  logic          data_rd,
  input  logic          trig_wr,
  input  logic          trig_rd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] req_vec,
  input  logic [DW-1:0] isr_vec,
  input  logic          poll_hit,
  input  logic [LW-1:0] poll_line,
  output logic [DW-1:0] mask,
  output logic [DW-1:0] trig_mode,
  output logic [BW-1:0] vec_base,
  output logic          auto_eoi,
  output logic          spec_nest,
  output logic          rot_on_aeoi,
  output logic          spec_mask,
  output logic          init_busy,
  output logic          init_p,
  output logic          eoi_p,
  output logic          eoi_specific,
  output logic          eoi_rotate,
  output logic          prio_set_p,
  output logic [LW-1:0] cmd_line,
  output logic [DW-1:0] req_clr,
  output logic [DW-1:0] isr_clr
);
  logic     is_init, is_rdcmd, is_opcmd;
  op2_t     op;
  init_st_t init_st;
  logic     poll_armed, read_isr, poll_rd;

  assign poll_rd   = poll_armed & (cmd_rd | data_rd);
  assign init_busy = (init_st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst)          trig_mode <= '0;
    else if (trig_wr) trig_mode <= wdata;
  end

  pic_cmd_decode #(.DW(DW)) u_dec (
    .cmd_wr(cmd_wr), .wdata(wdata), .is_init(is_init),
    .is_rdcmd(is_rdcmd), .is_opcmd(is_opcmd), .op(op)
  );

  pic_init_seq #(.DW(DW)) u_init (
    .clk(clk), .rst(rst), .is_init(is_init), .data_wr(data_wr),
    .wdata(wdata), .st(init_st), .mask(mask), .vec_base(vec_base),
    .auto_eoi(auto_eoi), .spec_nest(spec_nest), .init_p(init_p)
  );

  pic_op_ctl #(.DW(DW)) u_op (
    .clk(clk), .rst(rst), .is_init(is_init), .is_rdcmd(is_rdcmd),
    .is_opcmd(is_opcmd), .op(op), .wdata(wdata), .poll_rd(poll_rd),
    .poll_hit(poll_hit), .poll_line(poll_line), .trig_mode(trig_mode),
    .poll_armed(poll_armed), .read_isr(read_isr), .spec_mask(spec_mask),
    .rot_on_aeoi(rot_on_aeoi), .eoi_p(eoi_p), .eoi_specific(eoi_specific),
    .eoi_rotate(eoi_rotate), .prio_set_p(prio_set_p), .cmd_line(cmd_line),
    .req_clr(req_clr), .isr_clr(isr_clr)
  );

  pic_readback #(.DW(DW)) u_rb (
    .cmd_rd(cmd_rd), .data_rd(data_rd), .trig_rd(trig_rd),
    .poll_armed(poll_armed), .read_isr(read_isr), .poll_hit(poll_hit),
    .poll_line(poll_line), .req_vec(req_vec), .isr_vec(isr_vec),
    .mask(mask), .trig_mode(trig_mode), .rdata(rdata)
  );
endmodule

// File: rtl/pic_port_chk.sv
module pic_port_chk
  import pic_port_pkg::*;
#(
  parameter int DW = 8,
  localparam int LW = $clog2(DW),
  localparam int BW = DW - LW
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_wr,
  input logic          cmd_rd,
  input logic          data_wr,
  input logic          data_rd,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] mask,
  input logic [BW-1:0] vec_base,
  input logic          init_p,
  input logic          eoi_p,
  input logic [DW-1:0] req_clr,
  input logic [DW-1:0] isr_clr,
  input logic          poll_armed,
  input init_st_t      init_st
);
  a_r3_init_clears: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && wdata[4]) |=> (mask == '0 && vec_base == '0 && init_p));

  a_r5_idle_mask_load: assert property (@(posedge clk) disable iff (rst)
    (data_wr && !(cmd_wr && wdata[4]) && init_st == ST_IDLE) |=> (mask == $past(wdata)));

  a_r7_eoi_source: assert property (@(posedge clk) disable iff (rst)
    eoi_p |-> ($past(cmd_wr) && !$past(wdata[4]) && !$past(wdata[3]) && $past(wdata[5])));

  a_r10_poll_disarm: assert property (@(posedge clk) disable iff (rst)
    (poll_armed && (cmd_rd || data_rd) && !(cmd_wr && !wdata[4] && wdata[3] && wdata[2]))
    |=> !poll_armed);

  a_r10_single_clear: assert property (@(posedge clk) disable iff (rst)
    $onehot0(isr_clr));

  a_r12_rearm_wins: assert property (@(posedge clk) disable iff (rst)
    (poll_armed && cmd_rd && cmd_wr && wdata[4:2] == 3'b011) |=> poll_armed);
endmodule

bind pic_port_ctl pic_port_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_rd(cmd_rd), .data_wr(data_wr),
  .data_rd(data_rd), .wdata(wdata), .mask(mask), .vec_base(vec_base),
  .init_p(init_p), .eoi_p(eoi_p), .req_clr(req_clr), .isr_clr(isr_clr),
  .poll_armed(poll_armed), .init_st(init_st)
);

// File: tb/pic_port_ctl_tb.sv
module pic_port_ctl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_wr = 0, cmd_rd = 0, data_wr = 0, data_rd = 0, trig_wr = 0, trig_rd = 0;
  logic [7:0] wdata = 0, rdata, req_vec = 0, isr_vec = 0;
  logic       poll_hit = 0;
  logic [2:0] poll_line = 0;
  logic [7:0] mask, trig_mode, req_clr, isr_clr;
  logic [4:0] vec_base;
  logic       auto_eoi, spec_nest, rot_on_aeoi, spec_mask, init_busy, init_p;
  logic       eoi_p, eoi_specific, eoi_rotate, prio_set_p;
  logic [2:0] cmd_line;

  int nchk = 0, nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pic_port_ctl u_dut (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_rd(cmd_rd), .data_wr(data_wr),
    .data_rd(data_rd), .trig_wr(trig_wr), .trig_rd(trig_rd), .wdata(wdata),
    .rdata(rdata), .req_vec(req_vec), .isr_vec(isr_vec), .poll_hit(poll_hit),
    .poll_line(poll_line), .mask(mask), .trig_mode(trig_mode), .vec_base(vec_base),
    .auto_eoi(auto_eoi), .spec_nest(spec_nest), .rot_on_aeoi(rot_on_aeoi),
    .spec_mask(spec_mask), .init_busy(init_busy), .init_p(init_p), .eoi_p(eoi_p),
    .eoi_specific(eoi_specific), .eoi_rotate(eoi_rotate), .prio_set_p(prio_set_p),
    .cmd_line(cmd_line), .req_clr(req_clr), .isr_clr(isr_clr)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Each write is one strobe cycle; on return the registered result is visible.
  task automatic wr_cmd(logic [7:0] v);
    @(negedge clk); cmd_wr = 1; wdata = v;
    @(negedge clk); cmd_wr = 0;
  endtask
  task automatic wr_data(logic [7:0] v);
    @(negedge clk); data_wr = 1; wdata = v;
    @(negedge clk); data_wr = 0;
  endtask
  task automatic wr_trig(logic [7:0] v);
    @(negedge clk); trig_wr = 1; wdata = v;
    @(negedge clk); trig_wr = 0;
  endtask
  task automatic rd_port(int port, output logic [7:0] v);
    @(negedge clk);
    cmd_rd = (port == 0); data_rd = (port == 1); trig_rd = (port == 2);
    #1 v = rdata;
    @(negedge clk); cmd_rd = 0; data_rd = 0; trig_rd = 0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 mask", mask, 0);
    chk("R1 trig", trig_mode, 0);
    chk("R1 base", vec_base, 0);
    chk("R1 flags", {auto_eoi, spec_nest, rot_on_aeoi, spec_mask, init_busy}, 0);
    req_vec = 8'h5A; isr_vec = 8'hC3;
    rd_port(0, v);
    chk("R1 cmd read gives request", v, 8'h5A);
  endtask

  task automatic t_init_four();
    logic [7:0] v;
    wr_trig(8'h10);
    rd_port(2, v);
    chk("R11 trig readback", v, 8'h10);
    wr_data(8'h33);
    chk("R5 idle data loads mask", mask, 8'h33);
    wr_cmd(8'h11);
    chk("R2 init classified", init_p, 1);
    chk("R3 mask cleared", mask, 0);
    chk("R3 edge requests cleared", req_clr, 8'hEF);
    chk("R3 busy", init_busy, 1);
    wr_data(8'h75);
    chk("R5 base from bits 7:3", vec_base, 5'h0E);
    wr_data(8'hFF);
    chk("R5 cascade word ignored", mask, 0);
    chk("R5 mode word expected", init_busy, 1);
    wr_data(8'h13);
    chk("R6 spec_nest", spec_nest, 1);
    chk("R6 auto_eoi", auto_eoi, 1);
    chk("R5 done", init_busy, 0);
    wr_data(8'h5F);
    chk("R5 mask after sequence", mask, 8'h5F);
    rd_port(1, v);
    chk("R11 data read gives mask", v, 8'h5F);
  endtask

  task automatic t_init_three();
    wr_cmd(8'h11);
    chk("R4 flags kept with bit0", {spec_nest, auto_eoi}, 2'b11);
    wr_data(8'h08); wr_data(8'h00); wr_data(8'h02);
    chk("R6 mode word 0x02", {spec_nest, auto_eoi}, 2'b01);
    wr_cmd(8'h10);
    chk("R4 flags cleared without bit0", {spec_nest, auto_eoi}, 2'b00);
    wr_data(8'h08);
    chk("R5 base 1", vec_base, 5'h01);
    wr_data(8'hAA);
    chk("R5 no mode word", init_busy, 0);
    wr_data(8'h44);
    chk("R5 three-word mask", mask, 8'h44);
  endtask

  task automatic t_ocw2();
    wr_cmd(8'h20);
    chk("R7 nonspecific", {eoi_p, eoi_specific, eoi_rotate}, 3'b100);
    wr_cmd(8'h63);
    chk("R7 specific", {eoi_p, eoi_specific, eoi_rotate, cmd_line}, {3'b110, 3'd3});
    wr_cmd(8'hA0);
    chk("R7 rotating nonspecific", {eoi_p, eoi_specific, eoi_rotate}, 3'b101);
    wr_cmd(8'hE5);
    chk("R7 rotating specific", {eoi_p, eoi_specific, eoi_rotate, cmd_line}, {3'b111, 3'd5});
    wr_cmd(8'h80);
    chk("R8 rotate-on-aeoi set", {rot_on_aeoi, eoi_p, prio_set_p}, 3'b100);
    wr_cmd(8'h40);
    chk("R8 nop", {rot_on_aeoi, eoi_p, prio_set_p}, 3'b100);
    wr_cmd(8'h00);
    chk("R8 rotate-on-aeoi clear", rot_on_aeoi, 0);
    wr_cmd(8'hC6);
    chk("R8 set priority", {prio_set_p, eoi_p, cmd_line}, {2'b10, 3'd6});
  endtask

  task automatic t_ocw3();
    logic [7:0] v;
    req_vec = 8'h20; isr_vec = 8'h10;
    wr_cmd(8'h0B);
    chk("R2 read cmd no eoi", eoi_p, 0);
    rd_port(0, v);
    chk("R11 isr read", v, 8'h10);
    wr_cmd(8'h08);
    rd_port(0, v);
    chk("R9 select kept without enable", v, 8'h10);
    wr_cmd(8'h0A);
    rd_port(0, v);
    chk("R11 irr read", v, 8'h20);
    wr_cmd(8'h68);
    chk("R9 special mask set", spec_mask, 1);
    wr_cmd(8'h28);
    chk("R9 special mask kept", spec_mask, 1);
    wr_cmd(8'h48);
    chk("R9 special mask clear", spec_mask, 0);
  endtask

  task automatic t_poll();
    logic [7:0] v;
    poll_hit = 1; poll_line = 3'd5; req_vec = 8'h24;
    wr_cmd(8'h0C);
    rd_port(1, v);
    chk("R10 poll line", v, 8'h05);
    chk("R10 isr clear", isr_clr, 8'h20);
    chk("R10 req clear", req_clr, 8'h20);
    rd_port(0, v);
    chk("R10 disarmed", v, 8'h24);
    poll_hit = 0;
    wr_cmd(8'h0C);
    rd_port(0, v);
    chk("R10 none pending", v, 8'h07);
    chk("R10 no clears", {isr_clr, req_clr}, 16'h0);
  endtask

  task automatic t_same_cycle();
    logic [7:0] v;
    poll_hit = 1; poll_line = 3'd3;
    wr_cmd(8'h0C);
    @(negedge clk); cmd_rd = 1; cmd_wr = 1; wdata = 8'h0C;
    #1 v = rdata;
    @(negedge clk); cmd_rd = 0; cmd_wr = 0;
    chk("R12 read returns poll", v, 8'h03);
    chk("R12 clears issued", isr_clr, 8'h08);
    rd_port(1, v);
    chk("R12 still armed", v, 8'h03);
    rd_port(1, v);
    chk("R12 then disarmed", v, 8'h44);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_init_four();
    t_init_three();
    t_ocw2();
    t_ocw3();
    t_poll();
    t_same_cycle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule